// File: doc/BRIEF.md
# Serial Video Transmitter Control Register Bank

This block is the register bank that sits in front of a serial digital video transmitter. A host reads and writes it over a simple 32-bit register bus with a write strobe, a byte address and a combinational read path. The bank drives the enables of the transmitter core, the input bridge and the stream-to-video stage. It also holds a module-control word, the two payload-identifier line numbers and one payload word per data stream, in a luma bank and a chroma bank.

When the host writes the module-control word, a small decoder checks the requested video mode against the requested stream count. For an allowed pair, it stores the stream-interleave pattern and the payload line numbers that suit the mode, together with the written fields. For a combination that is not allowed, the whole control word and the line numbers stay as they were, and a flag reports the rejected write. Event wires from the transmitter land in a sticky interrupt status register, which is cleared by writing ones. One status bit, video lock, is a live copy of its input and cannot be cleared. Per-source enables and a global enable gate a single interrupt output.

Top module: `sdi_tx_ctrl_regs`

## Requirements
- R1: After reset, every register reads zero except the version register at 0x3C, which reads the VERSION parameter (default 0x00010200). All enables, the interrupt output, `cfg_bad` and the payload buses are low.
- R2: The enable register at 0x00 keeps bit 0 (`core_en`), bit 8 (`bridge_en`) and bit 9 (`strm_en`); its other bits read 0. Writing 0 drops all three enables on the next cycle.
- R3: The control register at 0x04 stores its writable fields and drives them on `ctrl_word`. The writable fields are mode in bits 6:4, fractional rate in bit 7, CRC/payload insert/payload overwrite/second-field payload/sync-bit insert in bits 12 to 16, ancillary/line-number/EDH/4:2:0 in bits 18 to 21, chroma payload in bit 23, stream-2-in-3G-A in bit 24, and stream-count code in bits 29:28. All other bits of the written data are dropped.
- R4: On an accepted control write, bits 10:8 take an interleave pattern decoded from the mode (0 HD, 1 SD, 2 3G-A, 3 3G-B, 4 6G, 5 12G, 6 and 7 spare) and the stream-count code (0 = 2, 1 = 4, 2 = 8, 3 = 16 streams). 3G-A gives 0 and 3G-B gives 1. 6G gives 3 with 4 streams and 2 with 8 streams. 12G gives 2 with 8 streams. Every other mode gives 0.
- R5: A 6G write with a stream count other than 4 or 8, or a 12G write with a count other than 8, is rejected. The control word and the line register are left unchanged, and `cfg_bad` and read bit 31 of 0x04 become 1. The next accepted control write clears them.
- R6: An accepted control write loads the line register at 0x18 with lines 9/322 for SD, 10/572 for HD, 3G, 6G and 12G, and 0/0 for the spare modes. The field-1 line sits in bits 10:0 and the field-2 line in bits 26:16. A direct write to 0x18 keeps only those two fields.
- R7: Luma payload word i is at 0x1C+4i and chroma payload word i is at 0x70+4i, for i below NSTRM. Each reads back as written and appears in bits 32i+31:32i of `luma_pay` or `chroma_pay`.
- R8: Interrupt status bits 0, 1, 9 and 10 at 0x10 are set by `evt_in` bits 0, 1, 3 and 4 and stay set until a 1 is written to them. An event in the same cycle as the clear leaves the bit set.
- R9: Status bit 8 follows `evt_in[2]` one cycle later, and writes to 0x10 have no effect on it.
- R10: The enable register at 0x14 keeps bits 0, 1, 8, 9 and 10, and the global enable at 0x0C keeps bit 0. `irq_out` is high when the global enable is set and some status bit is set together with its enable bit.
- R11: Addresses that are not mapped, including addresses not aligned to a word, read 0 and ignore writes. Writes to the version register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| evt_in | input | 5 | Events: reset done, alignment error, video lock (level), overflow, underflow |
| irq_out | output | 1 | Interrupt request |
| core_en | output | 1 | Transmitter core enable |
| bridge_en | output | 1 | Input bridge enable |
| strm_en | output | 1 | Stream-to-video stage enable |
| ctrl_word | output | 32 | Stored module-control word |
| cfg_bad | output | 1 | Last control write was rejected |
| line_f1 | output | 11 | Field-1 payload line |
| line_f2 | output | 11 | Field-2 payload line |
| luma_pay | output | NSTRM*32 | Luma payload words |
| chroma_pay | output | NSTRM*32 | Chroma payload words |

## Verification
A corrupted control word or line register shows up on the same cycle's read and on `ctrl_word` and the line outputs. A wrong decode therefore appears one cycle after the control write that caused it, and a rejected write that still changed state shows up the same way. A sticky bit that is lost or cleared wrongly shows up at the very next read of 0x10, and at once on `irq_out` when its enable is set. The video-lock bit shows a stale or latched value within one cycle of a change on its input. Each step of the bench compares every output against a model, and sweeps over all addresses catch writes that land on the wrong register.

// File: rtl/sdi_tx_ctrl_pkg.sv
package sdi_tx_ctrl_pkg;
    localparam int unsigned ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_ENA    = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_GIE    = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_ISR    = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_IER    = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_LINE   = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_LUMA   = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_VER    = 8'h3C;
    localparam logic [ADDR_W-1:0] OFS_CHROMA = 8'h70;

    typedef enum logic [2:0] {
        MD_HD = 3'd0, MD_SD = 3'd1, MD_3GA = 3'd2, MD_3GB = 3'd3,
        MD_6G = 3'd4, MD_12G = 3'd5, MD_SP6 = 3'd6, MD_SP7 = 3'd7
    } vmode_e;

    localparam int unsigned CB_MODE_LO = 4;
    localparam int unsigned CB_PAT_LO  = 8;
    localparam int unsigned CB_CNT_LO  = 28;
    localparam int unsigned LINE_W     = 11;
    localparam int unsigned F2_LO      = 16;

    localparam logic [31:0] ENA_MASK    = 32'h0000_0301;
    localparam logic [31:0] CTRL_WMASK  = 32'h31BD_F0F0;
    localparam logic [31:0] LINE_MASK   = 32'h07FF_07FF;
    localparam logic [31:0] IRQ_MASK    = 32'h0000_0703;
    localparam logic [31:0] STICKY_MASK = 32'h0000_0603;
    localparam int unsigned LOCK_BIT    = 8;
endpackage

// File: rtl/sdi_tx_mux_decode.sv
module sdi_tx_mux_decode
    import sdi_tx_ctrl_pkg::*;
(
    input  logic [2:0]        mode_i,
    input  logic [1:0]        cnt_i,
    output logic [2:0]        pat_o,
    output logic              bad_o,
    output logic [LINE_W-1:0] line1_o,
    output logic [LINE_W-1:0] line2_o
);
    vmode_e mode;
    assign mode = vmode_e'(mode_i);

    // cnt code: 0 -> 2, 1 -> 4, 2 -> 8, 3 -> 16 streams
    always_comb begin
        pat_o = 3'd0;
        bad_o = 1'b0;
        unique case (mode)
            MD_3GA: pat_o = 3'd0;
            MD_3GB: pat_o = 3'd1;
            MD_6G: begin
                if (cnt_i == 2'd1)      pat_o = 3'd3;
                else if (cnt_i == 2'd2) pat_o = 3'd2;
                else                    bad_o = 1'b1;
            end
            MD_12G: begin
                if (cnt_i == 2'd2) pat_o = 3'd2;
                else               bad_o = 1'b1;
            end
            default: pat_o = 3'd0;
        endcase
    end

    always_comb begin
        unique case (mode)
            MD_SD: begin
                line1_o = LINE_W'(9);
                line2_o = LINE_W'(322);
            end
            MD_SP6, MD_SP7: begin
                line1_o = '0;
                line2_o = '0;
            end
            default: begin
                line1_o = LINE_W'(10);
                line2_o = LINE_W'(572);
            end
        endcase
    end
endmodule

// File: rtl/sdi_tx_irq_bank.sv
module sdi_tx_irq_bank
    import sdi_tx_ctrl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  evt_i,
    input  logic        wr_isr_i,
    input  logic        wr_ier_i,
    input  logic        wr_gie_i,
    input  logic [31:0] wdata_i,
    output logic [31:0] isr_o,
    output logic [31:0] ier_o,
    output logic        gie_o,
    output logic        irq_o
);
    typedef struct packed {
        logic [31:0] isr;
        logic [31:0] ier;
        logic        gie;
    } irq_st_t;

    irq_st_t q, d;
    logic [31:0] set_v;

    always_comb begin
        set_v     = '0;
        set_v[0]  = evt_i[0];
        set_v[1]  = evt_i[1];
        set_v[9]  = evt_i[3];
        set_v[10] = evt_i[4];

        d = q;
        if (wr_isr_i) d.isr = q.isr & ~(wdata_i & STICKY_MASK);
        d.isr = (d.isr | set_v) & STICKY_MASK;
        d.isr[LOCK_BIT] = evt_i[2];
        if (wr_ier_i) d.ier = wdata_i & IRQ_MASK;
        if (wr_gie_i) d.gie = wdata_i[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign isr_o = q.isr;
    assign ier_o = q.ier;
    assign gie_o = q.gie;
    assign irq_o = q.gie & (|(q.isr & q.ier));

    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_o[0] && !(wr_isr_i && wdata_i[0])) |=> isr_o[0]);

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i[4] |=> isr_o[10]);

    // R9
    lock_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (isr_o[LOCK_BIT] == $past(evt_i[2])));
endmodule

// File: rtl/sdi_tx_ctrl_regs.sv
module sdi_tx_ctrl_regs
    import sdi_tx_ctrl_pkg::*;
#(
    parameter int unsigned NSTRM   = 8,
    parameter logic [31:0] VERSION = 32'h0001_0200
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [4:0]            evt_in,
    output logic                  irq_out,
    output logic                  core_en,
    output logic                  bridge_en,
    output logic                  strm_en,
    output logic [31:0]           ctrl_word,
    output logic                  cfg_bad,
    output logic [LINE_W-1:0]     line_f1,
    output logic [LINE_W-1:0]     line_f2,
    output logic [NSTRM*32-1:0]   luma_pay,
    output logic [NSTRM*32-1:0]   chroma_pay
);
    localparam int unsigned PAY_W = NSTRM * 32;

    typedef struct packed {
        logic [31:0]             ena;
        logic [31:0]             ctrl;
        logic                    bad;
        logic [31:0]             line;
        logic [NSTRM-1:0][31:0]  luma;
        logic [NSTRM-1:0][31:0]  chroma;
    } reg_st_t;

    reg_st_t q, d;

    logic [2:0]        dec_pat;
    logic              dec_bad;
    logic [LINE_W-1:0] dec_l1, dec_l2;
    logic [31:0]       isr_v, ier_v;
    logic              gie_v;

    sdi_tx_mux_decode u_dec (
        .mode_i  (bus_wdata[CB_MODE_LO+2:CB_MODE_LO]),
        .cnt_i   (bus_wdata[CB_CNT_LO+1:CB_CNT_LO]),
        .pat_o   (dec_pat),
        .bad_o   (dec_bad),
        .line1_o (dec_l1),
        .line2_o (dec_l2)
    );

    sdi_tx_irq_bank u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_in),
        .wr_isr_i (bus_we && (bus_addr == OFS_ISR)),
        .wr_ier_i (bus_we && (bus_addr == OFS_IER)),
        .wr_gie_i (bus_we && (bus_addr == OFS_GIE)),
        .wdata_i  (bus_wdata),
        .isr_o    (isr_v),
        .ier_o    (ier_v),
        .gie_o    (gie_v),
        .irq_o    (irq_out)
    );

    always_comb begin
        d = q;
        if (bus_we) begin
            if (bus_addr == OFS_ENA) begin
                d.ena = bus_wdata & ENA_MASK;
            end else if (bus_addr == OFS_CTRL) begin
                if (dec_bad) begin
                    d.bad = 1'b1;
                end else begin
                    d.ctrl = (bus_wdata & CTRL_WMASK) | (32'(dec_pat) << CB_PAT_LO);
                    d.bad  = 1'b0;
                    d.line = (32'(dec_l2) << F2_LO) | 32'(dec_l1);
                end
            end else if (bus_addr == OFS_LINE) begin
                d.line = bus_wdata & LINE_MASK;
            end
            for (int i = 0; i < NSTRM; i++) begin
                if (bus_addr == ADDR_W'(OFS_LUMA + 4 * i))   d.luma[i]   = bus_wdata;
                if (bus_addr == ADDR_W'(OFS_CHROMA + 4 * i)) d.chroma[i] = bus_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_ENA:  bus_rdata = q.ena;
            OFS_CTRL: bus_rdata = q.ctrl | {q.bad, 31'b0};
            OFS_GIE:  bus_rdata = {31'b0, gie_v};
            OFS_ISR:  bus_rdata = isr_v;
            OFS_IER:  bus_rdata = ier_v;
            OFS_LINE: bus_rdata = q.line;
            OFS_VER:  bus_rdata = VERSION;
            default:  bus_rdata = '0;
        endcase
        for (int i = 0; i < NSTRM; i++) begin
            if (bus_addr == ADDR_W'(OFS_LUMA + 4 * i))   bus_rdata = q.luma[i];
            if (bus_addr == ADDR_W'(OFS_CHROMA + 4 * i)) bus_rdata = q.chroma[i];
        end
    end

    assign core_en    = q.ena[0];
    assign bridge_en  = q.ena[8];
    assign strm_en    = q.ena[9];
    assign ctrl_word  = q.ctrl;
    assign cfg_bad    = q.bad;
    assign line_f1    = q.line[LINE_W-1:0];
    assign line_f2    = q.line[F2_LO+LINE_W-1:F2_LO];
    assign luma_pay   = PAY_W'(q.luma);
    assign chroma_pay = PAY_W'(q.chroma);

    // R2
    ena_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_ENA && bus_wdata == 32'd0)
            |=> (!core_en && !bridge_en && !strm_en));

    // R5
    bad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_CTRL && dec_bad)
            |=> ($stable(ctrl_word) && $stable(line_f1) && cfg_bad));
endmodule

// File: tb/sim_sdi_tx_ctrl_regs.sv
module sim_sdi_tx_ctrl_regs;
    localparam int NS = 8;
    localparam logic [31:0] VER = 32'h0001_0200;
    localparam logic [31:0] WM  = 32'h31BD_F0F0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_we = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [4:0] evt_p = '0;
    logic lock = 1'b0;
    logic [4:0] evt_in;
    logic irq_out, core_en, bridge_en, strm_en, cfg_bad;
    logic [31:0] ctrl_word;
    logic [10:0] line_f1, line_f2;
    logic [NS*32-1:0] luma_pay, chroma_pay;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] m_ena, m_ctrl, m_line, m_isr, m_ier;
    logic m_bad, m_gie, m_lock;
    logic [31:0] m_luma [NS];
    logic [31:0] m_chroma [NS];

    assign evt_in = {evt_p[4:3], lock, evt_p[1:0]};

    always #10 clk = ~clk;

    sdi_tx_ctrl_regs u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in),
        .irq_out(irq_out), .core_en(core_en), .bridge_en(bridge_en),
        .strm_en(strm_en), .ctrl_word(ctrl_word), .cfg_bad(cfg_bad),
        .line_f1(line_f1), .line_f2(line_f2), .luma_pay(luma_pay),
        .chroma_pay(chroma_pay)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void exp_dec(input logic [2:0] md, input logic [1:0] cn,
                                    output logic [2:0] p, output logic b,
                                    output logic [10:0] l1, output logic [10:0] l2);
        p = 3'd0; b = 1'b0;
        if (md == 3'd3) p = 3'd1;
        else if (md == 3'd4) begin
            if (cn == 2'd1) p = 3'd3; else if (cn == 2'd2) p = 3'd2; else b = 1'b1;
        end else if (md == 3'd5) begin
            if (cn == 2'd2) p = 3'd2; else b = 1'b1;
        end
        if (md == 3'd1) begin l1 = 11'd9; l2 = 11'd322; end
        else if (md <= 3'd5) begin l1 = 11'd10; l2 = 11'd572; end
        else begin l1 = 11'd0; l2 = 11'd0; end
    endfunction

    function automatic void mdl_write(input logic [7:0] a, input logic [31:0] v);
        logic [2:0] p; logic b; logic [10:0] l1, l2;
        case (a)
            8'h00: m_ena = v & 32'h0000_0301;
            8'h04: begin
                exp_dec(v[6:4], v[29:28], p, b, l1, l2);
                if (b) m_bad = 1'b1;
                else begin
                    m_ctrl = (v & WM) | (32'(p) << 8);
                    m_bad = 1'b0;
                    m_line = {5'b0, l2, 5'b0, l1};
                end
            end
            8'h0C: m_gie = v[0];
            8'h14: m_ier = v & 32'h0000_0703;
            8'h18: m_line = v & 32'h07FF_07FF;
            default: ;
        endcase
        for (int i = 0; i < NS; i++) begin
            if (a == 8'(8'h1C + 4 * i)) m_luma[i] = v;
            if (a == 8'(8'h70 + 4 * i)) m_chroma[i] = v;
        end
    endfunction

    function automatic logic [31:0] mdl_read(input logic [7:0] a);
        logic [31:0] r;
        r = '0;
        case (a)
            8'h00: r = m_ena;
            8'h04: r = m_ctrl | {m_bad, 31'b0};
            8'h0C: r = {31'b0, m_gie};
            8'h10: r = m_isr | (32'(m_lock) << 8);
            8'h14: r = m_ier;
            8'h18: r = m_line;
            8'h3C: r = VER;
            default: ;
        endcase
        for (int i = 0; i < NS; i++) begin
            if (a == 8'(8'h1C + 4 * i)) r = m_luma[i];
            if (a == 8'(8'h70 + 4 * i)) r = m_chroma[i];
        end
        return r;
    endfunction

    function automatic logic [7:0] addr_k(input int k);
        logic [7:0] t [13] = '{8'h00, 8'h04, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h3C,
                               8'h08, 8'h40, 8'h6C, 8'h90, 8'hFC, 8'h1D};
        if (k < 13) return t[k];
        if (k < 13 + NS) return 8'(8'h1C + 4 * (k - 13));
        return 8'(8'h70 + 4 * (k - 13 - NS));
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h00: return "R2";
            8'h04: return "R3";
            8'h0C, 8'h14: return "R10";
            8'h10: return "R8";
            8'h18: return "R6";
            8'h3C: return "R11 version";
            default: ;
        endcase
        if ((a >= 8'h1C && a < 8'h3C && a[1:0] == 2'b00) ||
            (a >= 8'h70 && a < 8'h90 && a[1:0] == 2'b00)) return "R7";
        return "R11 unmapped";
    endfunction

    task automatic step(input logic we, input logic [7:0] a, input logic [31:0] v,
                        input logic [4:0] p, input logic lk);
        logic [31:0] clr, pm;
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = v; evt_p = p; lock = lk;
        @(posedge clk);
        #1;
        if (we) mdl_write(a, v);
        clr = (we && a == 8'h10) ? (v & 32'h0000_0603) : 32'h0;
        pm = {21'b0, p[4], p[3], 7'b0, p[1], p[0]};
        m_isr = (m_isr & ~clr) | pm;
        m_lock = lk;
        bus_we = 1'b0; evt_p = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic sweep(input string pre);
        logic [31:0] v;
        for (int k = 0; k < 13 + 2 * NS; k++) begin
            rd(addr_k(k), v);
            chk({pre, tag_of(addr_k(k))}, v, mdl_read(addr_k(k)));
        end
    endtask

    task automatic chk_outs();
        logic [NS*32-1:0] el, ec;
        for (int i = 0; i < NS; i++) begin
            el[i*32 +: 32] = m_luma[i];
            ec[i*32 +: 32] = m_chroma[i];
        end
        chk("R2 enables", {29'b0, strm_en, bridge_en, core_en},
            {29'b0, m_ena[9], m_ena[8], m_ena[0]});
        chk("R3 ctrl_word", ctrl_word, m_ctrl);
        chk("R5 cfg_bad", {31'b0, cfg_bad}, {31'b0, m_bad});
        chk("R6 lines", {5'b0, line_f2, 5'b0, line_f1}, m_line);
        chk("R7 luma_pay", 32'(luma_pay != el), 32'd0);
        chk("R7 chroma_pay", 32'(chroma_pay != ec), 32'd0);
        chk("R10 irq_out", {31'b0, irq_out},
            {31'b0, m_gie & (|(mdl_read(8'h10) & m_ier))});
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v, seed;
        logic [2:0] p; logic b; logic [10:0] l1, l2;
        seed = $urandom(32'h5D1C_0DE5);
        m_ena = '0; m_ctrl = '0; m_line = '0; m_isr = '0; m_ier = '0;
        m_bad = 0; m_gie = 0; m_lock = 0;
        for (int i = 0; i < NS; i++) begin m_luma[i] = '0; m_chroma[i] = '0; end

        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        sweep("R1 reset / ");
        chk_outs();

        // R2 enable bits, then all off
        step(1, 8'h00, 32'hFFFF_FFFF, 5'b0, 0); chk_outs(); sweep("R2 ");
        step(1, 8'h00, 32'h0, 5'b0, 0); chk_outs();

        // R4 / R5 / R6 every mode and count pair
        for (int md = 0; md < 8; md++) begin
            for (int cn = 0; cn < 4; cn++) begin
                v = ($urandom & ~32'h3000_0070) | (32'(cn) << 28) | (32'(md) << 4);
                exp_dec(3'(md), 2'(cn), p, b, l1, l2);
                step(1, 8'h04, v, 5'b0, 0);
                rd(8'h04, v);
                chk(b ? "R5 rejected ctrl" : "R4 pattern", v, mdl_read(8'h04));
                chk("R6 lines after ctrl", {5'b0, line_f2, 5'b0, line_f1}, m_line);
                chk("R5 flag", {31'b0, cfg_bad}, {31'b0, b});
            end
        end

        // R8 sticky, clear, set wins over clear
        step(1, 8'h14, 32'hFFFF_FFFF, 5'b0, 0);
        step(1, 8'h0C, 32'h0, 5'b00010, 0); chk_outs();
        rd(8'h10, v); chk("R8 sticky set", v, 32'h2);
        step(1, 8'h0C, 32'h1, 5'b0, 0); chk_outs();
        step(1, 8'h10, 32'h2, 5'b00010, 0);
        rd(8'h10, v); chk("R8 set wins clear", v, 32'h2);
        step(1, 8'h10, 32'hFFFF_FFFF, 5'b0, 0);
        rd(8'h10, v); chk("R8 cleared", v, 32'h0); chk_outs();

        // R9 lock follows input, unaffected by writes
        step(0, 8'h00, 0, 5'b0, 1);
        step(1, 8'h10, 32'hFFFF_FFFF, 5'b0, 1);
        rd(8'h10, v); chk("R9 lock held", v, 32'h100); chk_outs();
        step(0, 8'h00, 0, 5'b0, 0);
        rd(8'h10, v); chk("R9 lock drop", v, 32'h0);

        // R11 unmapped and version writes
        for (int k = 7; k < 13; k++) step(1, addr_k(k), $urandom, 5'b0, 0);
        step(1, 8'h3C, 32'hDEAD_BEEF, 5'b0, 0);
        sweep("R11 after ignored writes / ");

        // Random mix
        for (int n = 0; n < 600; n++) begin
            logic [7:0] a;
            logic [31:0] d;
            a = addr_k(int'($urandom % (13 + 2 * NS)));
            d = $urandom;
            if (a == 8'h04 && ($urandom % 2) == 0) d[29:28] = 2'd2;
            step(($urandom % 4) != 0, a, d, 5'($urandom) & 5'b11011, ($urandom % 3) == 0);
            chk_outs();
            if (n % 100 == 99) sweep("random / ");
        end
        sweep("final / ");

        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end
endmodule